// File: doc/BRIEF.md
# Transmit Descriptor Next-Address Unit

This block works out where a transmit DMA engine should fetch its next descriptor. It keeps the address of the descriptor now being serviced. When the engine has decoded that descriptor's control word, it presents the decoded fields on a single-cycle request. The fields are the last-in-ring flag, the linked-mode flag, the second buffer byte count and the second address word.

One cycle later the block answers with a response pulse. The response carries the following:
- the next descriptor address;
- a protocol-error flag;
- an indication of whether a second data buffer exists;
- a one-cycle wrap strobe when the address is taken from the list base register.

Two list layouts are supported. In a packed ring, descriptors lie back to back. In a linked list, each descriptor names its successor through the second address word. The last-in-ring flag always takes precedence over linking. Descriptor fetch, buffer data movement and ownership handling belong to the surrounding engine.

Top module: `txd_next_walker`

## Requirements
- R1: After reset (synchronous, active-low `rst_n`), `cur_addr` equals `base_addr`, and `out_valid` and `wrap` are 0.
- R2: A request with `eor`=1 yields `next_addr` equal to `base_addr` and `wrap`=1 in the response cycle.
- R3: When `eor`=1, `chain` has no effect: the result is the base address and `proto_err`=0 whatever `bs2_len` holds.
- R4: A request with `eor`=0 and `chain`=1 yields `next_addr` equal to `addr2`, with `wrap`=0.
- R5: A request with `eor`=0, `chain`=1 and nonzero `bs2_len` raises `proto_err`=1 and leaves `cur_addr` unchanged. A zero `bs2_len` in that case gives `proto_err`=0.
- R6: A request with `eor`=0 and `chain`=0 yields `next_addr` = `cur_addr` + DESC_BYTES (16 by default), modulo 2^ADDR_W, with `wrap`=0.
- R7: `buf2_present`=1 exactly when the linked mode is not in effect (`eor`=1 or `chain`=0) and `bs2_len` is nonzero. `bs2_len` is an 11-bit byte count by default.
- R8: `out_valid` is high for exactly the one cycle after each cycle in which `req` is high, and never otherwise. `wrap` and `proto_err` are only high together with `out_valid`.
- R9: On a response without `proto_err`, `cur_addr` takes the value of `next_addr` in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_addr | input | ADDR_W | Descriptor list base address |
| req | input | 1 | Decoded fields are valid this cycle |
| eor | input | 1 | Descriptor is the last in the ring |
| chain | input | 1 | Second address word is the next descriptor pointer |
| bs2_len | input | BS2_W | Second buffer byte count |
| addr2 | input | ADDR_W | Second address word |
| out_valid | output | 1 | Response pulse, one cycle after `req` |
| next_addr | output | ADDR_W | Computed next descriptor address |
| proto_err | output | 1 | Linked descriptor with nonzero second size |
| buf2_present | output | 1 | Second data buffer exists |
| wrap | output | 1 | Next address came from the base register |
| cur_addr | output | ADDR_W | Descriptor address now being serviced |

## Verification
The bench builds the block with ADDR_W=12 and BS2_W=4, keeping DESC_BYTES=16. This makes every second-size value reachable in an exhaustive sweep against each mode-flag combination. With a base of 0xFF0, the packed-ring step crosses the top of the 12-bit address space and its modulo wraparound can be checked. Each base is swept through all 64 flag and size combinations. The bench keeps its own model of the current address, so the error-hold and follow rules are checked across long request sequences.

// File: rtl/txd_walk_pkg.sv
package txd_walk_pkg;
  typedef enum logic [1:0] {
    SRC_RING  = 2'd0,
    SRC_BASE  = 2'd1,
    SRC_CHAIN = 2'd2
  } next_src_e;
endpackage

// File: rtl/txd_next_sel.sv
module txd_next_sel
  import txd_walk_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int BS2_W      = 11,
  parameter int DESC_BYTES = 16
) (
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [ADDR_W-1:0] addr2,
  input  logic              eor,
  input  logic              chain,
  input  logic [BS2_W-1:0]  bs2_len,
  output next_src_e         src,
  output logic [ADDR_W-1:0] nxt,
  output logic              err,
  output logic              buf2
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DESC_BYTES);

  function automatic logic [ADDR_W-1:0] ring_step(input logic [ADDR_W-1:0] a);
    return a + STEP;
  endfunction

  logic size_nz;
  assign size_nz = |bs2_len;

  always_comb begin
    if (eor)        src = SRC_BASE;
    else if (chain) src = SRC_CHAIN;
    else            src = SRC_RING;
  end

  always_comb begin
    case (src)
      SRC_BASE:  nxt = base_addr;
      SRC_CHAIN: nxt = addr2;
      default:   nxt = ring_step(cur_addr);
    endcase
  end

  assign err  = (src == SRC_CHAIN) && size_nz;
  assign buf2 = (src != SRC_CHAIN) && size_nz;
endmodule

// File: rtl/txd_resp_reg.sv
module txd_resp_reg
  import txd_walk_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              req,
  input  next_src_e         src,
  input  logic [ADDR_W-1:0] nxt,
  input  logic              err,
  input  logic              buf2,
  output logic              out_valid,
  output logic [ADDR_W-1:0] next_addr,
  output logic              proto_err,
  output logic              buf2_present,
  output logic              wrap,
  output logic [ADDR_W-1:0] cur_addr
);
  logic advance;
  assign advance = req && !err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_addr     <= base_addr;
      out_valid    <= 1'b0;
      next_addr    <= '0;
      proto_err    <= 1'b0;
      buf2_present <= 1'b0;
      wrap         <= 1'b0;
    end else begin
      out_valid <= req;
      wrap      <= req && (src == SRC_BASE);
      proto_err <= req && err;
      if (req) begin
        next_addr    <= nxt;
        buf2_present <= buf2;
      end
      if (advance) cur_addr <= nxt;
    end
  end

  p_valid_follows_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> out_valid);
  p_valid_needs_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !out_valid);
  p_wrap_in_resp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |-> out_valid);
  p_err_in_resp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> out_valid);
  p_err_holds_cur_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req && err) |=> $stable(cur_addr));
  p_cur_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !proto_err) |-> (cur_addr == next_addr));
endmodule

// File: rtl/txd_next_walker.sv
module txd_next_walker
  import txd_walk_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int BS2_W      = 11,
  parameter int DESC_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              req,
  input  logic              eor,
  input  logic              chain,
  input  logic [BS2_W-1:0]  bs2_len,
  input  logic [ADDR_W-1:0] addr2,
  output logic              out_valid,
  output logic [ADDR_W-1:0] next_addr,
  output logic              proto_err,
  output logic              buf2_present,
  output logic              wrap,
  output logic [ADDR_W-1:0] cur_addr
);
  next_src_e         sel_src;
  logic [ADDR_W-1:0] sel_nxt;
  logic              sel_err;
  logic              sel_buf2;

  txd_next_sel #(.ADDR_W(ADDR_W), .BS2_W(BS2_W), .DESC_BYTES(DESC_BYTES)) u_sel (
    .base_addr(base_addr),
    .cur_addr (cur_addr),
    .addr2    (addr2),
    .eor      (eor),
    .chain    (chain),
    .bs2_len  (bs2_len),
    .src      (sel_src),
    .nxt      (sel_nxt),
    .err      (sel_err),
    .buf2     (sel_buf2)
  );

  txd_resp_reg #(.ADDR_W(ADDR_W)) u_resp (
    .clk         (clk),
    .rst_n       (rst_n),
    .base_addr   (base_addr),
    .req         (req),
    .src         (sel_src),
    .nxt         (sel_nxt),
    .err         (sel_err),
    .buf2        (sel_buf2),
    .out_valid   (out_valid),
    .next_addr   (next_addr),
    .proto_err   (proto_err),
    .buf2_present(buf2_present),
    .wrap        (wrap),
    .cur_addr    (cur_addr)
  );

  p_eor_picks_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req && eor) |=> (wrap && next_addr == $past(base_addr)));
  p_eor_no_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req && eor) |=> !proto_err);
  p_chain_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !eor && chain) |=> (!wrap && next_addr == $past(addr2)));
  p_no_buf2_when_linked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !eor && chain) |=> !buf2_present);
endmodule

// File: tb/tb_txd_next_walker.sv
module tb_txd_next_walker;
  localparam int AW = 12;
  localparam int BW = 4;
  localparam int DB = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic          req = 1'b0;
  logic          eor = 1'b0;
  logic          chain = 1'b0;
  logic [BW-1:0] bs2_len = '0;
  logic [AW-1:0] addr2 = '0;
  logic          out_valid, proto_err, buf2_present, wrap;
  logic [AW-1:0] next_addr, cur_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [AW-1:0] m_cur;

  always #10 clk = ~clk;

  txd_next_walker #(.ADDR_W(AW), .BS2_W(BW), .DESC_BYTES(DB)) dut (
    .clk(clk), .rst_n(rst_n), .base_addr(base_addr), .req(req), .eor(eor),
    .chain(chain), .bs2_len(bs2_len), .addr2(addr2), .out_valid(out_valid),
    .next_addr(next_addr), .proto_err(proto_err), .buf2_present(buf2_present),
    .wrap(wrap), .cur_addr(cur_addr)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input bit e, input bit c, input int s, input int a2);
    logic [AW-1:0] exp_n;
    bit linked, exp_err, exp_b2;
    @(negedge clk);
    eor = e; chain = c; bs2_len = BW'(s); addr2 = AW'(a2); req = 1'b1;
    linked  = !e && c;
    exp_err = linked && (s != 0);
    exp_b2  = !linked && (s != 0);
    if (e)      exp_n = base_addr;
    else if (c) exp_n = AW'(a2);
    else        exp_n = AW'(int'(m_cur) + DB);
    @(negedge clk);
    req = 1'b0;
    chk(out_valid == 1'b1, "R8 valid", int'(out_valid), 1);
    if (e)      chk(next_addr == exp_n, "R2 base", int'(next_addr), int'(exp_n));
    else if (c) chk(next_addr == exp_n, "R4 chain", int'(next_addr), int'(exp_n));
    else        chk(next_addr == exp_n, "R6 ring", int'(next_addr), int'(exp_n));
    chk(wrap == e, "R2 wrap", int'(wrap), int'(e));
    chk(proto_err == exp_err, e ? "R3 err" : "R5 err", int'(proto_err), int'(exp_err));
    chk(buf2_present == exp_b2, "R7 buf2", int'(buf2_present), int'(exp_b2));
    if (!exp_err) m_cur = exp_n;
    chk(cur_addr == m_cur, exp_err ? "R5 hold" : "R9 follow", int'(cur_addr), int'(m_cur));
  endtask

  initial begin
    int bases[4] = '{12'h100, 12'hFF0, 12'h7A0, 12'h000};
    base_addr = 12'h100;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cur_addr == 12'h100, "R1 cur", int'(cur_addr), 12'h100);
    chk(out_valid == 1'b0, "R1 valid", int'(out_valid), 0);
    chk(wrap == 1'b0, "R1 wrap", int'(wrap), 0);
    m_cur = 12'h100;
    foreach (bases[i]) begin
      base_addr = AW'(bases[i]);
      issue(1'b1, 1'b0, 0, 0);
      for (int r = 0; r < 20; r++) issue(1'b0, 1'b0, r % 3, 12'h555);
      for (int k = 0; k < 64; k++) begin
        issue(k[5], k[4], k[3:0], (k * 37 + 12'h240) & 12'hFF0);
        @(negedge clk);
        chk(out_valid == 1'b0, "R8 idle valid", int'(out_valid), 0);
        chk(wrap == 1'b0, "R8 idle wrap", int'(wrap), 0);
      end
    end
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule